// File: doc/BRIEF.md
# Dual-Clock System Clock Controller

This block chooses the system clock from one of two sources: a fast main oscillator or a slow 32768 Hz sub oscillator. A 4-bit control register sets three things: the source, whether the main oscillator runs, and the watchdog prescale. The sub oscillator always runs, so the register, its write port and the write checks sit in the sub-clock domain. A settle counter in the main-clock domain models the main oscillator's stable time. It counts main-clock cycles after the enable.

The block checks every register write against the switching rules before it stores the value. The source and the main enable must never change in the same write. The source may return to the main clock only once the main oscillator has settled. The encoding that selects a stopped main clock is refused. A refused write leaves the register as it was and sets a sticky error flag.

The output clock passes through a glitch-free handover. The old source is gated off on its own falling edge. The new source is then gated on after two synchronizer stages in its own domain. STOP halts the main oscillator and gates the system clock. HOLD gates the system clock and leaves the oscillator running.

Top module: `sysclk_ctl`

## Requirements
- R1: After reset the register reads 0000, `main_osc_en` is 1, `wr_err` is 0 and `wdt_div_sel` is 0. Once the main oscillator has settled, `sys_clk` toggles at the main-clock rate.
- R2: Register bit 0 selects the source: 0 gives the main clock on `sys_clk` and 1 gives the sub clock.
- R3: `main_osc_en` is 0 whenever register bit 1 is 1 or `stop_req` is 1, and is 1 otherwise.
- R4: A write whose low two bits are binary 10 is refused. The register keeps its value and `wr_err` is set.
- R5: A write that would change both bit 0 and bit 1 at once is refused. The register keeps its value and `wr_err` is set.
- R6: A write that clears bit 0 while bit 1 is 0 is accepted only after the settle counter has seen SETTLE main-clock cycles with the oscillator enabled. Before that, the write is refused and `wr_err` is set.
- R7: Register bit 2 drives `wdt_div_sel`: 0 selects system clock / 2048 and 1 selects system clock / 16384. Bits 2 and 3 can be written freely in any legal write.
- R8: `wr_err` stays set after a later legal write and clears only on reset.
- R9: The two clock gates are never open together. `sys_clk` never shows a high pulse shorter than half a main-clock period.
- R10: While `stop_req` or `hold_req` is 1, `sys_clk` stays low. HOLD leaves `main_osc_en` at 1. After STOP ends, the main clock returns to `sys_clk` once the oscillator has settled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main | input | 1 | Main oscillator clock |
| clk_sub | input | 1 | Sub oscillator clock (always running) |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, sub-clock domain |
| wr_data | input | 4 | Value to write to the control register |
| stop_req | input | 1 | STOP request: halts the main oscillator and the system clock |
| hold_req | input | 1 | HOLD request: gates the system clock |
| sys_clk | output | 1 | Selected, gated system clock |
| main_osc_en | output | 1 | Main oscillator enable |
| wdt_div_sel | output | 1 | Watchdog prescale select (0: /2048, 1: /16384) |
| ctrl_q | output | 4 | Current control register value |
| wr_err | output | 1 | Sticky error flag for refused writes |

## Verification
The assertions check four things on every sub-clock cycle:
- the register never holds the forbidden low-bit encoding;
- bit 0 and bit 1 never change in the same cycle;
- bit 0 falls only while the synchronized settle flag is high;
- the error flag never clears and the two clock gates are never open together.

Only the bench scenarios can show the following:
- the actual rate of `sys_clk` on each source;
- that it goes quiet under STOP and HOLD;
- that no short pulse appears across a handover;
- that an early switch back to the main clock is refused while a later one is accepted.

// File: rtl/sysclk_ctl.sv
`timescale 1ns/1ps
module sysclk_ctl #(
  parameter int SETTLE = 1024
) (
  input  logic       clk_main,
  input  logic       clk_sub,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_data,
  input  logic       stop_req,
  input  logic       hold_req,
  output logic       sys_clk,
  output logic       main_osc_en,
  output logic       wdt_div_sel,
  output logic [3:0] ctrl_q,
  output logic       wr_err
);
  localparam int CW = $clog2(SETTLE + 1);

  logic          en_m1, en_m2;
  logic [CW-1:0] settle_cnt;
  logic          rdy_m, rdy_s1, rdy_s;
  logic          m_s1, m_s2, m_gate;
  logic          s_s1, s_s2, s_gate;
  logic          run, req_main, req_sub, bad_wr;
  logic [1:0]    cur, nxt;

  assign main_osc_en = ~ctrl_q[1] & ~stop_req;
  assign wdt_div_sel = ctrl_q[2];
  assign run         = ~stop_req & ~hold_req;

  always_ff @(posedge clk_main or negedge rst_n)
    if (!rst_n) begin
      en_m1 <= 1'b0;
      en_m2 <= 1'b0;
    end else begin
      en_m1 <= main_osc_en;
      en_m2 <= en_m1;
    end

  always_ff @(posedge clk_main or negedge rst_n)
    if (!rst_n)
      settle_cnt <= '0;
    else if (!en_m2)
      settle_cnt <= '0;
    else if (settle_cnt != CW'(SETTLE))
      settle_cnt <= settle_cnt + 1'b1;

  assign rdy_m = en_m2 && (settle_cnt == CW'(SETTLE));

  always_ff @(posedge clk_sub or negedge rst_n)
    if (!rst_n) begin
      rdy_s1 <= 1'b0;
      rdy_s  <= 1'b0;
    end else begin
      rdy_s1 <= rdy_m;
      rdy_s  <= rdy_s1;
    end

  assign cur    = ctrl_q[1:0];
  assign nxt    = wr_data[1:0];
  assign bad_wr = (nxt == 2'b10)
                | ((cur[0] ^ nxt[0]) & (cur[1] ^ nxt[1]))
                | (cur[0] & ~nxt[0] & ~cur[1] & ~rdy_s);

  always_ff @(posedge clk_sub or negedge rst_n)
    if (!rst_n) begin
      ctrl_q <= 4'b0000;
      wr_err <= 1'b0;
    end else if (wr_en) begin
      if (bad_wr) wr_err <= 1'b1;
      else        ctrl_q <= wr_data;
    end

  assign req_main = ~ctrl_q[0] & ~s_gate & run & rdy_m;
  assign req_sub  =  ctrl_q[0] & ~m_gate & run;

  always_ff @(posedge clk_main or negedge rst_n)
    if (!rst_n) begin
      m_s1 <= 1'b0;
      m_s2 <= 1'b0;
    end else begin
      m_s1 <= req_main;
      m_s2 <= m_s1;
    end

  always_ff @(negedge clk_main or negedge rst_n)
    if (!rst_n) m_gate <= 1'b0;
    else        m_gate <= m_s2;

  always_ff @(posedge clk_sub or negedge rst_n)
    if (!rst_n) begin
      s_s1 <= 1'b0;
      s_s2 <= 1'b0;
    end else begin
      s_s1 <= req_sub;
      s_s2 <= s_s1;
    end

  always_ff @(negedge clk_sub or negedge rst_n)
    if (!rst_n) s_gate <= 1'b0;
    else        s_gate <= s_s2;

  assign sys_clk = (clk_main & m_gate) | (clk_sub & s_gate);

  a_r4_no_forbidden: assert property (@(posedge clk_sub) disable iff (!rst_n)
    ctrl_q[1:0] != 2'b10);

  a_r4_reject_keeps: assert property (@(posedge clk_sub) disable iff (!rst_n)
    (wr_en && wr_data[1:0] == 2'b10) |=> ($stable(ctrl_q) && wr_err));

  a_r5_one_step: assert property (@(posedge clk_sub) disable iff (!rst_n)
    $countones(ctrl_q[1:0] ^ $past(ctrl_q[1:0])) <= 1);

  a_r6_settled_first: assert property (@(posedge clk_sub) disable iff (!rst_n)
    $fell(ctrl_q[0]) |-> $past(rdy_s));

  a_r8_err_sticky: assert property (@(posedge clk_sub) disable iff (!rst_n)
    wr_err |=> wr_err);

  a_r9_gates_exclusive: assert property (@(posedge clk_sub) disable iff (!rst_n)
    !(m_gate && s_gate));
endmodule

// File: tb/tb_sysclk_ctl.sv
`timescale 1ns/1ps
module tb_sysclk_ctl;
  logic clk_main = 0, clk_sub = 0, rst_n = 0;
  logic wr_en = 0, stop_req = 0, hold_req = 0;
  logic [3:0] wr_data = 0;
  logic sys_clk, main_osc_en, wdt_div_sel, wr_err;
  logic [3:0] ctrl_q;
  int checks = 0, fails = 0, edges = 0, glitches = 0;
  realtime rise_t = 0;

  sysclk_ctl #(.SETTLE(32)) dut (
    .clk_main(clk_main), .clk_sub(clk_sub), .rst_n(rst_n),
    .wr_en(wr_en), .wr_data(wr_data), .stop_req(stop_req), .hold_req(hold_req),
    .sys_clk(sys_clk), .main_osc_en(main_osc_en), .wdt_div_sel(wdt_div_sel),
    .ctrl_q(ctrl_q), .wr_err(wr_err));

  always #5 clk_main = ~clk_main;
  always #35 clk_sub = ~clk_sub;

  always @(posedge sys_clk) begin
    edges++;
    rise_t = $realtime;
  end
  always @(negedge sys_clk)
    if ($realtime - rise_t < 4.9) glitches++;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rate(string req, int exp);
    int e0, d;
    e0 = edges;
    #1400;
    d = edges - e0;
    checks++;
    if (d < exp - 3 || d > exp + 3) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d edges", req, d, exp);
    end
  endtask

  task automatic wr(logic [3:0] d);
    @(negedge clk_sub);
    wr_en = 1; wr_data = d;
    @(negedge clk_sub);
    wr_en = 0;
  endtask

  task automatic t_reset;
    chk("R1 ctrl", ctrl_q, 0);
    chk("R1 main_osc_en", main_osc_en, 1);
    chk("R1 wr_err", wr_err, 0);
    chk("R1 wdt_div_sel", wdt_div_sel, 0);
    #1000;
    chk_rate("R1 main rate", 140);
  endtask

  task automatic t_wdt;
    wr(4'b0100);
    chk("R7 ctrl", ctrl_q, 4'b0100);
    chk("R7 wdt=1", wdt_div_sel, 1);
    wr(4'b1000);
    chk("R7 ctrl bit3", ctrl_q, 4'b1000);
    chk("R7 wdt=0", wdt_div_sel, 0);
    wr(4'b0000);
    chk("R7 err clean", wr_err, 0);
  endtask

  task automatic t_to_sub;
    wr(4'b0001);
    chk("R2 ctrl", ctrl_q, 4'b0001);
    #600;
    chk_rate("R2 sub rate", 20);
    chk("R9 glitches", glitches, 0);
  endtask

  task automatic t_main_off;
    wr(4'b0011);
    chk("R3 ctrl", ctrl_q, 4'b0011);
    chk("R3 main_osc_en off", main_osc_en, 0);
    chk("R3 err clean", wr_err, 0);
  endtask

  task automatic t_both;
    wr(4'b0000);
    chk("R5 ctrl kept", ctrl_q, 4'b0011);
    chk("R5 err", wr_err, 1);
  endtask

  task automatic t_sticky;
    wr(4'b0001);
    chk("R8 legal write ctrl", ctrl_q, 4'b0001);
    chk("R8 err stays", wr_err, 1);
    chk("R3 main_osc_en on", main_osc_en, 1);
  endtask

  task automatic t_settle;
    wr(4'b0000);
    chk("R6 early reject", ctrl_q, 4'b0001);
    #1000;
    wr(4'b0000);
    chk("R6 settled accept", ctrl_q, 4'b0000);
    #600;
    chk_rate("R2 main rate back", 140);
    chk("R9 glitches", glitches, 0);
  endtask

  task automatic t_forbid;
    wr(4'b0010);
    chk("R4 ctrl kept", ctrl_q, 4'b0000);
    wr(4'b0011);
    chk("R5 ctrl kept 00->11", ctrl_q, 4'b0000);
  endtask

  task automatic t_stop;
    @(negedge clk_sub);
    stop_req = 1;
    #1;
    chk("R3 stop osc off", main_osc_en, 0);
    #600;
    chk_rate("R10 stop quiet", 0);
    stop_req = 0;
    #1;
    chk("R3 stop released", main_osc_en, 1);
    #1000;
    chk_rate("R10 stop resume", 140);
  endtask

  task automatic t_hold;
    @(negedge clk_sub);
    hold_req = 1;
    #1;
    chk("R10 hold osc on", main_osc_en, 1);
    #300;
    chk_rate("R10 hold quiet", 0);
    hold_req = 0;
    #300;
    chk_rate("R10 hold resume", 140);
    chk("R9 glitches", glitches, 0);
  endtask

  task automatic t_rst_err;
    rst_n = 0;
    #50;
    chk("R8 reset clears err", wr_err, 0);
    chk("R1 reset ctrl", ctrl_q, 0);
  endtask

  initial begin
    #100;
    @(negedge clk_sub);
    rst_n = 1;
    #1;
    t_reset();
    t_wdt();
    t_to_sub();
    t_main_off();
    t_both();
    t_sticky();
    t_settle();
    t_forbid();
    t_stop();
    t_hold();
    t_rst_err();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #150000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule